// File: doc/BRIEF.md
# Up-Counting Overflow Event Timer

A 32-bit timer whose counter climbs by one on every cycle where the functional count enable is high, and which raises an overflow event when the count steps past all-ones. Software asks for an interval by loading the complement of it. To wait N ticks beyond the tick that reaches all-ones, it loads `0xFFFFFFFF - N` and starts the counter. For a steady tick of P counts it loads `0xFFFFFFFF - (P-1)` and sets auto-reload. With auto-reload clear, the timer fires once and stops. With auto-reload set, the counter takes the load value again on every wrap.

A small word-addressed register port gives access to:
- the control bits,
- the load value,
- the live counter,
- a combined load-and-start operation,
- the interrupt enable,
- a write-one-to-clear overflow status,
- a mode bit, and
- a pending mask.

In posted mode, writes to the four timing registers go first into per-register holding slots. Each slot has a two-state machine, `SL_IDLE` and `SL_WAIT`. A write moves the slot from `SL_IDLE` to `SL_WAIT`. The slot returns to `SL_IDLE` when its countdown expires and the value lands, or when a direct write supersedes it. A new posted write while in `SL_WAIT` restarts the countdown.

The counter core has two states, `RS_STOP` and `RS_RUN`:
- `RS_STOP` to `RS_RUN`: a control write with the run bit set, or a load-and-start.
- `RS_RUN` to `RS_STOP`: a control write with the run bit clear, or a wrap with auto-reload clear.

Reads are combinational and always immediate, so the counter can be sampled at any time.

Top module: `ovt_timer`

## Requirements
- R1: After reset the counter, the load value, the control bits (address 0: bit0 run, bit1 auto-reload), the status, the enable, the posted-mode bit and the pending mask all read 0, and `irq` is low.
- R2: In the running state the counter (address 2) rises by exactly one on each clock where `cnt_en` is high, and holds where it is low.
- R3: A tick taken while the counter is 0xFFFFFFFF sets status bit0 (address 5). Starting from load value L, this happens on the (2^32 - L)th enabled tick.
- R4: With auto-reload clear, the wrap leaves the counter at 0 and clears the run bit, and further ticks leave the counter at 0.
- R5: With auto-reload set, the wrap copies the load register (address 1) into the counter and the timer keeps running, so the period is 2^32 - L ticks (a load of 0 gives a free run over the full range).
- R6: A control write with bit0 clear stops the count; the counter then ignores `cnt_en`.
- R7: A write to address 3 puts its data into both the load register and the counter and sets the run bit, leaving auto-reload as it was.
- R8: Writing 1 to status bit0 clears it, and writing 0 leaves it unchanged. If an overflow and a clear fall in the same cycle, the flag stays set.
- R9: `irq` is high exactly when status bit0 and enable bit0 (address 4) are both 1.
- R10: With mode bit0 (address 6) clear, a write to addresses 0 to 3 takes effect at the write edge. With it set, the write takes effect POST_LAT cycles later. Meanwhile bit k of the pending mask (address 7) is 1 for address k, and it returns to 0 when the value lands.
- R11: A second posted write to a register whose slot is still pending replaces the held data and restarts the POST_LAT countdown, so the earlier value never lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register port and the counter |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Functional count enable, one tick per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt, gated by the enable |

## Verification
The bench targets the off-by-one traps around the wrap:
- It checks the counter at all-ones with the flag still clear, then the very next tick. A design that fired one tick early or late would fail one of those two samples.
- It sets up an overflow in the same cycle as a status clear. A design that let the clear win would lose an event.

The posted path is sampled on each cycle between the write and the landing. A design with the wrong latency would show the new value a cycle early or late. A design that did not restart on a second write would briefly expose the stale value.

One-shot checks that the counter stays parked at zero after the wrap. A design that merely masked the event there would keep counting.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

    localparam int NUM_POST = 4;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_COUNT = 3'd2,
        A_LDGO  = 3'd3,
        A_IEN   = 3'd4,
        A_STAT  = 3'd5,
        A_CFG   = 3'd6,
        A_PEND  = 3'd7
    } addr_e;

    typedef enum logic {
        RS_STOP = 1'b0,
        RS_RUN  = 1'b1
    } run_state_e;

    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_WAIT = 1'b1
    } slot_state_e;

endpackage

// File: rtl/ovt_post_slot.sv
module ovt_post_slot
    import ovt_pkg::*;
#(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post_en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    output logic [DW-1:0] cdata,
    output logic          pending
);

    localparam int RW = (LAT < 2) ? 1 : $clog2(LAT);

    slot_state_e    state_q, state_d;
    logic [RW-1:0]  rem_q, rem_d;
    logic [DW-1:0]  hold_q, hold_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            rem_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            hold_q  <= hold_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        hold_d  = hold_q;
        unique case (state_q)
            SL_IDLE: begin
                if (wr && post_en) begin
                    state_d = SL_WAIT;
                    rem_d   = RW'(LAT - 1);
                    hold_d  = wdata;
                end
            end
            SL_WAIT: begin
                if (wr && post_en) begin
                    rem_d  = RW'(LAT - 1);
                    hold_d = wdata;
                end else if (wr) begin
                    state_d = SL_IDLE;
                end else if (rem_q == '0) begin
                    state_d = SL_IDLE;
                end else begin
                    rem_d = rem_q - RW'(1);
                end
            end
            default: state_d = SL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit  = 1'b0;
        cdata   = hold_q;
        pending = (state_q == SL_WAIT);
        if (wr && !post_en) begin
            commit = 1'b1;
            cdata  = wdata;
        end else if ((state_q == SL_WAIT) && (rem_q == '0) && !wr) begin
            commit = 1'b1;
        end
    end

endmodule

// File: rtl/ovt_core.sv
module ovt_core
    import ovt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          ctrl_wr,
    input  logic          ctrl_run,
    input  logic          ctrl_rel,
    input  logic          load_wr,
    input  logic [CW-1:0] load_val,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_val,
    input  logic          go_wr,
    input  logic [CW-1:0] go_val,
    output logic [CW-1:0] count,
    output logic [CW-1:0] load,
    output logic          run,
    output logic          reload,
    output logic          ovf
);

    run_state_e    state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic [CW-1:0] load_q, load_d;
    logic          rel_q, rel_d;
    logic          at_top;

    assign at_top = (count_q == {CW{1'b1}});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_STOP;
            count_q <= '0;
            load_q  <= '0;
            rel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            load_q  <= load_d;
            rel_q   <= rel_d;
        end
    end

    // next-state logic: counting first, software writes override
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        load_d  = load_q;
        rel_d   = rel_q;
        unique case (state_q)
            RS_STOP: begin
                count_d = count_q;
            end
            RS_RUN: begin
                if (cnt_en) begin
                    if (at_top) begin
                        if (rel_q) begin
                            count_d = load_q;
                        end else begin
                            count_d = '0;
                            state_d = RS_STOP;
                        end
                    end else begin
                        count_d = count_q + CW'(1);
                    end
                end
            end
            default: state_d = RS_STOP;
        endcase
        if (ctrl_wr) begin
            rel_d   = ctrl_rel;
            state_d = ctrl_run ? RS_RUN : RS_STOP;
        end
        if (load_wr) load_d = load_val;
        if (cnt_wr)  count_d = cnt_val;
        if (go_wr) begin
            load_d  = go_val;
            count_d = go_val;
            state_d = RS_RUN;
        end
    end

    // outputs
    always_comb begin
        ovf    = (state_q == RS_RUN) && cnt_en && at_top;
        count  = count_q;
        load   = load_q;
        run    = (state_q == RS_RUN);
        reload = rel_q;
    end

endmodule

// File: rtl/ovt_irq.sv
module ovt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ien_wr,
    input  logic stat_wr,
    input  logic wbit,
    input  logic ovf,
    output logic ien,
    output logic stat,
    output logic irq
);

    logic ien_q;
    logic stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (ien_wr) ien_q <= wbit;
            if (ovf) begin
                stat_q <= 1'b1;
            end else if (stat_wr && wbit) begin
                stat_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ien  = ien_q;
        stat = stat_q;
        irq  = stat_q & ien_q;
    end

endmodule

// File: rtl/ovt_timer.sv
module ovt_timer
    import ovt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int POST_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    logic                 post_en_q;
    logic [NUM_POST-1:0]  slot_commit;
    logic [NUM_POST-1:0]  slot_pend;
    logic [CNT_W-1:0]     slot_data [NUM_POST];

    logic [CNT_W-1:0]     count;
    logic [CNT_W-1:0]     load;
    logic                 run;
    logic                 reload;
    logic                 ovf;
    logic                 ien;
    logic                 stat;
    logic                 unused_ctrl_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_en_q <= 1'b0;
        end else if (bus_we && (bus_addr == A_CFG)) begin
            post_en_q <= bus_wdata[0];
        end
    end

    for (genvar gi = 0; gi < NUM_POST; gi++) begin : g_slot
        ovt_post_slot #(
            .DW  (CNT_W),
            .LAT (POST_LAT)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .post_en (post_en_q),
            .wr      (bus_we && (bus_addr == 3'(gi))),
            .wdata   (bus_wdata),
            .commit  (slot_commit[gi]),
            .cdata   (slot_data[gi]),
            .pending (slot_pend[gi])
        );
    end

    assign unused_ctrl_bits = ^slot_data[A_CTRL][CNT_W-1:2];

    ovt_core #(
        .CW (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .ctrl_wr  (slot_commit[A_CTRL]),
        .ctrl_run (slot_data[A_CTRL][0]),
        .ctrl_rel (slot_data[A_CTRL][1]),
        .load_wr  (slot_commit[A_LOAD]),
        .load_val (slot_data[A_LOAD]),
        .cnt_wr   (slot_commit[A_COUNT]),
        .cnt_val  (slot_data[A_COUNT]),
        .go_wr    (slot_commit[A_LDGO]),
        .go_val   (slot_data[A_LDGO]),
        .count    (count),
        .load     (load),
        .run      (run),
        .reload   (reload),
        .ovf      (ovf)
    );

    ovt_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (bus_we && (bus_addr == A_IEN)),
        .stat_wr (bus_we && (bus_addr == A_STAT)),
        .wbit    (bus_wdata[0]),
        .ovf     (ovf),
        .ien     (ien),
        .stat    (stat),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e'(bus_addr))
            A_CTRL:  bus_rdata = {{(CNT_W-2){1'b0}}, reload, run};
            A_LOAD:  bus_rdata = load;
            A_COUNT: bus_rdata = count;
            A_LDGO:  bus_rdata = '0;
            A_IEN:   bus_rdata = {{(CNT_W-1){1'b0}}, ien};
            A_STAT:  bus_rdata = {{(CNT_W-1){1'b0}}, stat};
            A_CFG:   bus_rdata = {{(CNT_W-1){1'b0}}, post_en_q};
            A_PEND:  bus_rdata = {{(CNT_W-NUM_POST){1'b0}}, slot_pend};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ovt_timer_chk.sv
module ovt_timer_chk #(
    parameter int CW = 32,
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_en,
    input logic          bus_we,
    input logic [2:0]    bus_addr,
    input logic [CW-1:0] bus_wdata,
    input logic          post_en,
    input logic          ovf,
    input logic          stat,
    input logic          run,
    input logic          reload,
    input logic [CW-1:0] count,
    input logic [CW-1:0] load,
    input logic [NP-1:0] commit,
    input logic [NP-1:0] pend
);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run && cnt_en && (count != {CW{1'b1}}) && (commit == '0)
        |=> count == $past(count) + CW'(1));

    assert_stat_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> stat);

    assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !reload && (commit == '0) |=> !run && (count == '0));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && reload && (commit == '0) |=> run && (count == $past(load)));

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run && (commit == '0) |=> $stable(count));

    assert_direct_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == 3'd1) && !post_en && !commit[3]
        |=> load == $past(bus_wdata));

    assert_post_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == 3'd1) && post_en |=> pend[1]);

endmodule

bind ovt_timer ovt_timer_chk #(
    .CW (CNT_W),
    .NP (ovt_pkg::NUM_POST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .post_en   (post_en_q),
    .ovf       (ovf),
    .stat      (stat),
    .run       (run),
    .reload    (reload),
    .count     (count),
    .load      (load),
    .commit    (slot_commit),
    .pend      (slot_pend)
);

// File: tb/ovt_timer_bench.sv
module ovt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    ovt_timer u_ovt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        if (q.size() > 0) begin
            it = q.pop_front();
            act = it.is_irq ? {31'd0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        q.push_back('{1'b0, e, tag});
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(posedge clk); #1;
        q.push_back('{1'b1, {31'd0, e}, tag});
    endtask

    task automatic tick(input int n);
        @(posedge clk); #1;
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 cnt_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, 32'h0, "R1 ctrl");
        rd(3'd1, 32'h0, "R1 load");
        rd(3'd2, 32'h0, "R1 count");
        rd(3'd5, 32'h0, "R1 stat");
        rd(3'd7, 32'h0, "R1 pend");
        chk_irq(1'b0, "R1 irq");

        // R10 direct write lands at the write edge
        wr(3'd1, 32'h0000_1234);
        rd(3'd1, 32'h0000_1234, "R10 direct load");

        // R2 counting and holding
        wr(3'd2, 32'd5);
        wr(3'd0, 32'd1);
        tick(3);
        rd(3'd2, 32'd8, "R2 three ticks");
        repeat (2) @(posedge clk);
        rd(3'd2, 32'd8, "R2 hold without enable");

        // R6 stop
        wr(3'd0, 32'd0);
        tick(4);
        rd(3'd2, 32'd8, "R6 stopped ignores ticks");

        // R3/R4/R7 one-shot with N=4
        wr(3'd3, 32'hFFFF_FFFB);
        rd(3'd0, 32'd1, "R7 load-and-start runs");
        tick(4);
        rd(3'd2, 32'hFFFF_FFFF, "R3 at top");
        rd(3'd5, 32'd0, "R3 not yet");
        tick(1);
        rd(3'd5, 32'd1, "R3 overflow flag");
        rd(3'd2, 32'd0, "R4 parked at zero");
        rd(3'd0, 32'd0, "R4 run cleared");
        tick(3);
        rd(3'd2, 32'd0, "R4 stays at zero");

        // R9/R8 interrupt masking and clear
        chk_irq(1'b0, "R9 masked");
        wr(3'd4, 32'd1);
        chk_irq(1'b1, "R9 enabled");
        wr(3'd5, 32'd0);
        rd(3'd5, 32'd1, "R8 write zero no effect");
        wr(3'd5, 32'd1);
        rd(3'd5, 32'd0, "R8 w1c");
        chk_irq(1'b0, "R9 cleared");

        // R5/R7 periodic, P=3
        wr(3'd0, 32'd2);
        rd(3'd0, 32'd2, "R6 reload set while stopped");
        wr(3'd3, 32'hFFFF_FFFD);
        rd(3'd0, 32'd3, "R7 keeps reload");
        tick(3);
        rd(3'd5, 32'd1, "R5 first period");
        rd(3'd2, 32'hFFFF_FFFD, "R5 reloaded");
        wr(3'd5, 32'd1);
        tick(2);
        rd(3'd5, 32'd0, "R5 mid period");
        rd(3'd2, 32'hFFFF_FFFF, "R5 at top");
        // R8 overflow and clear in the same cycle
        @(posedge clk); #1;
        cnt_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'd1;
        @(posedge clk); #1;
        cnt_en = 1'b0; bus_we = 1'b0;
        rd(3'd5, 32'd1, "R8 set wins over clear");
        rd(3'd2, 32'hFFFF_FFFD, "R5 second reload");
        wr(3'd0, 32'd0);

        // R10 posted latency
        wr(3'd6, 32'd1);
        wr(3'd1, 32'h0000_ABCD);
        rd(3'd7, 32'h2, "R10 pending bit");
        rd(3'd1, 32'hFFFF_FFFD, "R10 not landed early");
        rd(3'd1, 32'h0000_ABCD, "R10 landed on time");
        rd(3'd7, 32'h0, "R10 pending cleared");

        // R11 restart on repeated posted write
        wr(3'd2, 32'h10);
        wr(3'd2, 32'h20);
        rd(3'd2, 32'hFFFF_FFFD, "R11 stale value never lands");
        rd(3'd7, 32'h4, "R11 still pending");
        rd(3'd2, 32'h20, "R11 latest value lands");

        // R10 posted control
        wr(3'd0, 32'd1);
        rd(3'd0, 32'd0, "R10 ctrl not landed");
        rd(3'd7, 32'h1, "R10 ctrl pending");
        rd(3'd0, 32'd1, "R10 ctrl landed");
        wr(3'd6, 32'd0);
        wr(3'd0, 32'd0);
        rd(3'd0, 32'd0, "R6 direct stop");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule